// File: doc/BRIEF.md
# I2C Slave Address Recognition Unit

This unit monitors an I2C bus and decides whether the local slave is being addressed by the first byte after a START. SCL and SDA are synchronised into the core clock and checked for START and STOP conditions. The eight address bits are then collected, most significant bit first, on rising SCL edges. Software provides a 7-bit own address, a general-call enable and an acknowledge enable. When the byte matches, the unit sets an interrupt flag, publishes an 8-bit status code and, if acknowledge is enabled, pulls SDA low for the ninth clock.

A transmitter elsewhere in the slave can report the end of a transmission: the last byte was sent with acknowledge disabled and the master still acknowledged it. The unit then reports a dedicated status. When software clears that status, the acknowledge-enable bit decides whether the slave keeps recognising its address or goes deaf. A start request made at that moment is held until the bus is free and then issued as a single-cycle pulse.

All pins are plain control and status levels or pulses. None of them carries a data stream, so the unit has no valid/ready interface and no back-pressure.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset the interrupt flag is 0, status reads 0xF8, `sda_low_o` and `start_gen_o` are 0, address recognition is armed and the bus counts as free.
- R2: In slave mode with recognition armed, an address byte whose upper seven bits equal a nonzero `own_addr_i` sets `irq_o`. Bit 0 is the read/write bit and is the last of the eight bits shifted in. Status becomes 0x60 when bit 0 is 0 (write) and 0xA8 when bit 0 is 1 (read).
- R3: The byte 0x00 is a general call. It sets `irq_o` with status 0x70 only when `gc_en_i` is 1. The byte 0x01 never matches, and 0x00 does not match when `gc_en_i` is 0.
- R4: While `slv_mode_i` is 0, no address byte raises the interrupt or drives SDA.
- R5: On a match with `ack_en_i` at 1, `sda_low_o` goes high after the SCL fall that ends the eighth bit and drops after the SCL fall that ends the ninth. A match with `ack_en_i` at 0, or any non-matching byte, drives nothing.
- R6: `irq_o` stays set until an `int_clr_i` pulse, and status reads 0xF8 whenever `irq_o` is 0. A new event in the same cycle as a clear takes priority over the clear.
- R7: A `tx_last_i` pulse sets `irq_o` with status 0xC8.
- R8: Clearing the interrupt while status is 0xC8 disarms recognition if `ack_en_i` is 0. Disarmed, neither the own address nor a general call is recognised until `ack_en_i` rises again. If `ack_en_i` is 1 at the clear, recognition stays armed.
- R9: Clearing status 0xC8 with `sta_i` at 1 stores a pending START. `start_gen_o` then pulses for exactly one cycle once the bus is free: free at reset and after a STOP, busy from a START until the next STOP. The pending request is dropped once it has been issued.
- R10: An address byte that matches neither the own address nor an enabled general call leaves `irq_o` at 0 and status at 0xF8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| own_addr_i | input | 7 | Own slave address |
| gc_en_i | input | 1 | General-call recognition enable |
| slv_mode_i | input | 1 | Interface enabled in slave mode |
| ack_en_i | input | 1 | Acknowledge enable |
| sta_i | input | 1 | Start request |
| tx_last_i | input | 1 | Pulse: last transmitted byte acknowledged with acknowledge disabled |
| int_clr_i | input | 1 | Pulse: clear interrupt flag |
| sda_low_o | output | 1 | Pull SDA low (acknowledge) |
| irq_o | output | 1 | Interrupt flag |
| status_o | output | 8 | Status code |
| start_gen_o | output | 1 | One-cycle request to emit a START |

## Verification
The assertions rely on the configuration inputs `slv_mode_i` and `gc_en_i` staying steady while an address byte is on the bus. They also rely on SDA changing only while SCL is low, except for genuine START and STOP conditions. The bench meets both conditions: every bus phase lasts eight core clocks, which is longer than the synchroniser delay, and the configuration is changed only between transactions, after a STOP.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int unsigned STAT_W = 8;
  localparam logic [STAT_W-1:0] ST_OWN_WR = 8'h60;
  localparam logic [STAT_W-1:0] ST_GCALL  = 8'h70;
  localparam logic [STAT_W-1:0] ST_OWN_RD = 8'hA8;
  localparam logic [STAT_W-1:0] ST_TXLAST = 8'hC8;
  localparam logic [STAT_W-1:0] ST_IDLE   = 8'hF8;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } bus_evt_t;
endpackage

// File: rtl/i2c_bus_edges.sv
module i2c_bus_edges
  import i2c_am_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_i,
  input  logic     sda_i,
  output logic     scl_s,
  output logic     sda_s,
  output bus_evt_t evt
);
  localparam int unsigned PW = SYNC_STAGES + 1;

  logic [PW-1:0] scl_pipe, sda_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[PW-2:0], scl_i};
      sda_pipe <= {sda_pipe[PW-2:0], sda_i};
    end
  end

  logic scl_p, sda_p;
  assign scl_s = scl_pipe[SYNC_STAGES-1];
  assign sda_s = sda_pipe[SYNC_STAGES-1];
  assign scl_p = scl_pipe[SYNC_STAGES];
  assign sda_p = sda_pipe[SYNC_STAGES];

  always_comb begin
    evt.start = scl_s & scl_p & sda_p & ~sda_s;
    evt.stop  = scl_s & scl_p & ~sda_p & sda_s;
    evt.rise  = scl_s & ~scl_p;
    evt.fall  = ~scl_s & scl_p;
  end
endmodule

// File: rtl/i2c_addr_shift.sv
module i2c_addr_shift
  import i2c_am_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_evt_t          evt,
  input  logic              sda_s,
  output logic [BYTE_W-1:0] byte_o,
  output logic              done_o
);
  localparam int unsigned CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic          active;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      byte_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (evt.start) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (evt.stop) begin
        active <= 1'b0;
      end else if (active && evt.rise) begin
        byte_o <= {byte_o[BYTE_W-2:0], sda_s};
        cnt    <= cnt + 1'b1;
        if (cnt == LAST) begin
          done_o <= 1'b1;
          active <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
#(
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              gc_en_i,
  input  logic              slv_mode_i,
  input  logic              ack_en_i,
  input  logic              sta_i,
  input  logic              tx_last_i,
  input  logic              int_clr_i,
  output logic              sda_low_o,
  output logic              irq_o,
  output logic [STAT_W-1:0] status_o,
  output logic              start_gen_o
);
  localparam int unsigned BYTE_W = ADDR_W + 1;

  logic              scl_s, sda_s;
  bus_evt_t          evt;
  logic [BYTE_W-1:0] abyte;
  logic              adone;

  i2c_bus_edges #(.SYNC_STAGES(SYNC_STAGES)) u_edges (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .evt(evt)
  );

  i2c_addr_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .evt(evt), .sda_s(sda_s),
    .byte_o(abyte), .done_o(adone)
  );

  // Match decode
  logic [ADDR_W-1:0] a_field;
  logic              rw_bit, own_hit, gc_hit, hit, new_evt, leave_txlast;
  logic [STAT_W-1:0] code_q, hit_code;
  logic              armed, ack_en_q, bus_free, pend_start, ack_arm;

  always_comb begin
    a_field      = abyte[BYTE_W-1:1];
    rw_bit       = abyte[0];
    own_hit      = (a_field == own_addr_i) && (a_field != '0);
    gc_hit       = (a_field == '0) && !rw_bit && gc_en_i;
    hit          = adone && slv_mode_i && armed && (own_hit || gc_hit);
    hit_code     = gc_hit ? ST_GCALL : (rw_bit ? ST_OWN_RD : ST_OWN_WR);
    new_evt      = hit || tx_last_i;
    leave_txlast = int_clr_i && irq_o && (code_q == ST_TXLAST) && !new_evt;
  end

  // Interrupt flag and status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o  <= 1'b0;
      code_q <= ST_IDLE;
    end else if (hit) begin
      irq_o  <= 1'b1;
      code_q <= hit_code;
    end else if (tx_last_i) begin
      irq_o  <= 1'b1;
      code_q <= ST_TXLAST;
    end else if (int_clr_i) begin
      irq_o  <= 1'b0;
    end
  end

  assign status_o = irq_o ? code_q : ST_IDLE;

  // Re-arm control and pending START
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed       <= 1'b1;
      ack_en_q    <= 1'b0;
      bus_free    <= 1'b1;
      pend_start  <= 1'b0;
      start_gen_o <= 1'b0;
    end else begin
      ack_en_q    <= ack_en_i;
      start_gen_o <= 1'b0;
      if (leave_txlast)               armed <= ack_en_i;
      else if (ack_en_i && !ack_en_q) armed <= 1'b1;
      if (evt.start)     bus_free <= 1'b0;
      else if (evt.stop) bus_free <= 1'b1;
      if (leave_txlast && sta_i) begin
        pend_start <= 1'b1;
      end else if (pend_start && bus_free) begin
        pend_start  <= 1'b0;
        start_gen_o <= 1'b1;
      end
    end
  end

  // Acknowledge drive during the ninth clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_arm   <= 1'b0;
      sda_low_o <= 1'b0;
    end else if (evt.start || evt.stop) begin
      ack_arm   <= 1'b0;
      sda_low_o <= 1'b0;
    end else begin
      if (hit && ack_en_i) ack_arm <= 1'b1;
      if (evt.fall) begin
        if (ack_arm) begin
          sda_low_o <= 1'b1;
          ack_arm   <= 1'b0;
        end else if (sda_low_o) begin
          sda_low_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       bus_free,
  input logic       gc_en_i,
  input logic       slv_mode_i,
  input logic       int_clr_i,
  input logic       sda_low_o,
  input logic       irq_o,
  input logic [7:0] status_o,
  input logic       start_gen_o
);
  // R5: acknowledge drive starts only while SCL is low
  a_r5_ack_on_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low_o) |-> !scl_s);
  // R6: flag holds without a clear
  a_r6_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !int_clr_i |=> irq_o);
  // R3: general-call status needs the enable
  a_r3_gc_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) && status_o == 8'h70 |-> gc_en_i);
  // R4: address interrupts only in slave mode
  a_r4_slave_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) && status_o != 8'hC8 |-> slv_mode_i);
  // R9: start request is a single pulse
  a_r9_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    start_gen_o |=> !start_gen_o);
  // R9: start request issued only from a free bus
  a_r9_start_free: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_gen_o) |-> $past(bus_free));
  // R6: status is one of the defined codes
  a_r6_status_known: assert property (@(posedge clk) disable iff (!rst_n)
    status_o inside {8'h60, 8'h70, 8'hA8, 8'hC8, 8'hF8});
endmodule

bind i2c_addr_match i2c_addr_match_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .bus_free(bus_free),
  .gc_en_i(gc_en_i), .slv_mode_i(slv_mode_i), .int_clr_i(int_clr_i),
  .sda_low_o(sda_low_o), .irq_o(irq_o), .status_o(status_o),
  .start_gen_o(start_gen_o)
);

// File: tb/i2c_addr_match_tb_top.sv
module i2c_addr_match_tb_top;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [6:0] own_addr = 7'h5A;
  logic gc_en = 1'b0, slv_mode = 1'b1, ack_en = 1'b1, sta = 1'b0;
  logic tx_last = 1'b0, int_clr = 1'b0;
  logic sda_low, irq, start_gen;
  logic [7:0] status;
  logic sda_line;

  int n_chk = 0, n_err = 0, sg_cnt = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_low;

  i2c_addr_match dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .own_addr_i(own_addr), .gc_en_i(gc_en), .slv_mode_i(slv_mode),
    .ack_en_i(ack_en), .sta_i(sta), .tx_last_i(tx_last), .int_clr_i(int_clr),
    .sda_low_o(sda_low), .irq_o(irq), .status_o(status), .start_gen_o(start_gen)
  );

  always @(posedge clk) if (start_gen) sg_cnt <= sg_cnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic half_wait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; half_wait();
    sda_m = 1'b0; half_wait();
    scl_m = 1'b0; half_wait();
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; sda_m = 1'b0; half_wait();
    scl_m = 1'b1; half_wait();
    sda_m = 1'b1; half_wait();
  endtask

  task automatic bus_bit(input logic b);
    sda_m = b; half_wait();
    scl_m = 1'b1; half_wait();
    scl_m = 1'b0; half_wait();
  endtask

  // Driver: one address transaction; pushes the expected status on a hit
  task automatic send_addr(input logic [7:0] b, input bit exp_hit,
                           input logic [7:0] code, input bit exp_ack, input string req);
    if (exp_hit) exp_q.push_back(code);
    bus_start();
    for (int i = 7; i >= 0; i--) bus_bit(b[i]);
    sda_m = 1'b1; half_wait();
    chk(sda_low == exp_ack, {req, " R5 ack drive"}, sda_low, exp_ack);
    scl_m = 1'b1; half_wait();
    scl_m = 1'b0; half_wait();
    chk(sda_low == 1'b0, {req, " R5 ack release"}, sda_low, 0);
    bus_stop();
    if (!exp_hit) begin
      chk(irq == 1'b0, {req, " R10 no irq"}, irq, 0);
      chk(status == 8'hF8, {req, " R10 idle status"}, status, 8'hF8);
    end
  endtask

  task automatic clear_irq();
    @(negedge clk) int_clr = 1'b1;
    @(negedge clk) int_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk(irq == 1'b0, "R6 cleared", irq, 0);
    chk(status == 8'hF8, "R6 idle status", status, 8'hF8);
  endtask

  task automatic pulse_txlast();
    exp_q.push_back(8'hC8);
    @(negedge clk) tx_last = 1'b1;
    @(negedge clk) tx_last = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Monitor: compare each new interrupt against the scoreboard queue
  initial begin
    forever begin
      @(posedge irq);
      @(negedge clk);
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected irq", status, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(status == e, "R2/R3/R7 status code", status, e);
      end
    end
  end

  task automatic run_all();
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq == 0, "R1 irq", irq, 0);
    chk(status == 8'hF8, "R1 status", status, 8'hF8);
    chk(sda_low == 0, "R1 sda", sda_low, 0);
    chk(start_gen == 0, "R1 start_gen", start_gen, 0);

    send_addr(8'hB4, 1, 8'h60, 1, "R2 own write"); clear_irq();
    send_addr(8'hB5, 1, 8'hA8, 1, "R2 own read");  clear_irq();
    send_addr(8'hB6, 0, 8'h00, 0, "R10 mismatch");
    send_addr(8'h00, 0, 8'h00, 0, "R3 gc disabled");
    gc_en = 1'b1;
    send_addr(8'h00, 1, 8'h70, 1, "R3 gc enabled"); clear_irq();
    send_addr(8'h01, 0, 8'h00, 0, "R3 gc read bit");
    gc_en = 1'b0;
    ack_en = 1'b0;
    send_addr(8'hB4, 1, 8'h60, 0, "R5 no ack when disabled"); clear_irq();
    ack_en = 1'b1;
    slv_mode = 1'b0;
    send_addr(8'hB4, 0, 8'h00, 0, "R4 master mode");
    slv_mode = 1'b1;

    // R7 / R8: leave the tx-last state with acknowledge disabled
    pulse_txlast();
    chk(status == 8'hC8, "R7 status", status, 8'hC8);
    ack_en = 1'b0;
    clear_irq();
    gc_en = 1'b1;
    send_addr(8'hB4, 0, 8'h00, 0, "R8 deaf own");
    send_addr(8'h00, 0, 8'h00, 0, "R8 deaf gc");
    ack_en = 1'b1;
    repeat (2) @(negedge clk);
    send_addr(8'hB4, 1, 8'h60, 1, "R8 re-armed"); clear_irq();

    // R8: leave with acknowledge enabled keeps recognition
    pulse_txlast();
    clear_irq();
    send_addr(8'h00, 1, 8'h70, 1, "R8 stays armed gc"); clear_irq();
    gc_en = 1'b0;

    // R6: new event wins over a clear in the same cycle
    pulse_txlast();
    @(negedge clk) begin int_clr = 1'b1; tx_last = 1'b1; end
    @(negedge clk) begin int_clr = 1'b0; tx_last = 1'b0; end
    repeat (2) @(negedge clk);
    chk(irq == 1'b1, "R6 event over clear", irq, 1);
    chk(status == 8'hC8, "R6 event status", status, 8'hC8);
    clear_irq();

    // R9: start request on a free bus
    base = sg_cnt;
    pulse_txlast();
    sta = 1'b1;
    clear_irq();
    repeat (6) @(negedge clk);
    chk(sg_cnt == base + 1, "R9 start on free bus", sg_cnt - base, 1);
    repeat (10) @(negedge clk);
    chk(sg_cnt == base + 1, "R9 single pulse", sg_cnt - base, 1);
    sta = 1'b0;

    // R9: start request held while the bus is busy
    base = sg_cnt;
    bus_start();
    pulse_txlast();
    sta = 1'b1;
    clear_irq();
    sta = 1'b0;
    repeat (20) @(negedge clk);
    chk(sg_cnt == base, "R9 held while busy", sg_cnt - base, 0);
    bus_stop();
    repeat (6) @(negedge clk);
    chk(sg_cnt == base + 1, "R9 issued after stop", sg_cnt - base, 1);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R1 watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule